// File: doc/BRIEF.md
# Correlated Double Sampling Sequencer

This block steps the analog front end of one pixel through a correlated double sampling cycle. The readout sends a start request. The block then closes and opens the front-end switches in a fixed order. Integrator reset and discriminator reset are asserted together, and the integrator reset is released first. On the cycle in which the discriminator reset is released, the block strobes the first (pedestal) sample. Next it pulses the threshold/test injection and waits a settle interval so that the integrator output can come to rest. It then strobes the second sample. Finally it raises the readout mux select, so that the two stored samples can be driven off as a difference.

Every interval is a count of clock cycles taken from a configuration word. The word is latched when a start request is accepted. The same word carries the front-end polarity select and the 3-bit input-capacitance select; the block presents both on its outputs for the whole cycle. During the window in which the discriminator is live, the block watches the discriminator output. It latches the first rising edge as a hit flag for the digital tier. That flag is held until the next cycle begins.

Top module: `cds_seq`

## Requirements
- R1: While reset is asserted and after it is released, int_rst, disc_rst, inject, samp_pre, samp_post, mux_sel, busy, done and hit_out are 0, cap_sel is 3'b111 and invert is 0.
- R2: A start that is high at a clock edge while busy is 0 begins a cycle. From the next cycle, int_rst and disc_rst are both 1, and int_rst stays 1 for max(I,1) cycles.
- R3: When int_rst falls, disc_rst stays 1 for max(D,1) more cycles. In the first cycle after disc_rst falls, samp_pre is 1 for exactly one cycle.
- R4: Directly after the samp_pre cycle, inject is 1 for max(J,1) cycles.
- R5: After inject falls, all switch outputs stay low for a settle interval of S cycles. When S is 0 the interval is the default, round(300 ns / clock period), which is 15 cycles at the default 20 ns. samp_post is then 1 for exactly one cycle.
- R6: Directly after samp_post, mux_sel is 1 for max(R,1) cycles. busy is 1 from the first int_rst cycle through the last mux_sel cycle. done is 1 for exactly the one cycle after mux_sel falls.
- R7: At most one of disc_rst, inject, samp_pre, samp_post and mux_sel is 1 in any cycle. int_rst is 1 only while disc_rst is 1.
- R8: A start request while busy is 1 is ignored. The cycle in progress keeps its schedule and length.
- R9: cfg_word fields are cap_sel [2:0], invert [3], I [11:4], D [19:12], J [27:20], S [35:28] and R [43:36]. The whole word is latched when a start is accepted. cap_sel and invert then output the latched values until the next accepted start, and later changes to cfg_word have no effect.
- R10: In the cycles from samp_pre through the last mux_sel cycle, a rising edge of hit_in sets hit_out from the next cycle. hit_out then holds 1, through done and idle, until the next accepted start clears it.
- R11: A rising edge of hit_in outside that window, or a level that was already high when the window opened, does not set hit_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Cycle request from readout |
| cfg_word | input | 44 | Configuration word (field layout in R9) |
| hit_in | input | 1 | Discriminator output, synchronous to clk |
| int_rst | output | 1 | Integrator reset switch |
| disc_rst | output | 1 | Discriminator reset switch |
| inject | output | 1 | Threshold/test injection |
| samp_pre | output | 1 | First (pedestal) sample strobe |
| samp_post | output | 1 | Second sample strobe |
| mux_sel | output | 1 | Differential readout mux select |
| cap_sel | output | 3 | Input capacitance select (111 least, 000 most) |
| invert | output | 1 | Polarity select, 1 = inverting path |
| hit_out | output | 1 | Latched hit flag to digital tier |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
The assertions check the ordering invariants on every cycle. These are: the switch outputs are mutually exclusive, int_rst stays nested inside disc_rst, and the first sample follows the falling edge of disc_rst. They also check that mux_sel follows the second sample, that done follows mux_sel, that a cycle begins only from idle, that the capacitance and polarity outputs hold while busy, and that the hit flag persists. The exact length of every interval, the zero-means-one and zero-means-default count rules, the masking of a late start and of mid-cycle configuration changes, and the hit window edges can be shown only by the bench's scenarios. The bench compares every cycle against a schedule computed from the configuration.

// File: rtl/cds_pkg.sv
package cds_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_IRST,
        PH_DRST,
        PH_PRE,
        PH_INJ,
        PH_SETTLE,
        PH_POST,
        PH_READ
    } phase_e;

    // Discriminator is live from the first sample until readout ends
    function automatic logic phase_armed(phase_e p);
        return (p == PH_PRE) || (p == PH_INJ) || (p == PH_SETTLE) ||
               (p == PH_POST) || (p == PH_READ);
    endfunction

endpackage

// File: rtl/cds_timer.sv
module cds_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cds_hit_latch.sv
module cds_hit_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    input  logic hit_in,
    output logic hit_out
);

    typedef struct packed {
        logic prev;
        logic hit;
    } hl_t;

    hl_t hl_d, hl_q;

    always_comb begin
        hl_d      = hl_q;
        hl_d.prev = hit_in;
        if (clear) begin
            hl_d.hit = 1'b0;
        end else if (arm && hit_in && !hl_q.prev) begin
            hl_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hl_q <= '0;
        else        hl_q <= hl_d;
    end

    assign hit_out = hl_q.hit;

endmodule

// File: rtl/cds_seq.sv
module cds_seq #(
    parameter int CNT_W         = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int SETTLE_NS     = 300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [4+5*CNT_W-1:0] cfg_word,
    input  logic                 hit_in,
    output logic                 int_rst,
    output logic                 disc_rst,
    output logic                 inject,
    output logic                 samp_pre,
    output logic                 samp_post,
    output logic                 mux_sel,
    output logic [2:0]           cap_sel,
    output logic                 invert,
    output logic                 hit_out,
    output logic                 busy,
    output logic                 done
);
    import cds_pkg::*;

    localparam int CFG_W   = 4 + 5*CNT_W;
    localparam int INV_B   = 3;
    localparam int IRST_LSB = 4;
    localparam int DRST_LSB = IRST_LSB + CNT_W;
    localparam int INJ_LSB  = DRST_LSB + CNT_W;
    localparam int SET_LSB  = INJ_LSB + CNT_W;
    localparam int READ_LSB = SET_LSB + CNT_W;
    localparam int SETTLE_RAW = (SETTLE_NS + CLK_PERIOD_NS/2) / CLK_PERIOD_NS;
    localparam int SETTLE_DEF = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam logic [CNT_W-1:0] SETTLE_M1 = CNT_W'(SETTLE_DEF - 1);
    localparam logic [CFG_W-1:0] CFG_RST   = CFG_W'(7);

    typedef struct packed {
        phase_e           ph;
        logic [CFG_W-1:0] cfg;
        logic             done;
    } seq_t;

    seq_t             st_d, st_q;
    logic             tm_load;
    logic [CNT_W-1:0] tm_val;
    logic             tm_exp;
    logic             hit_clr;

    // Count N lasts max(N,1) cycles
    function automatic logic [CNT_W-1:0] len_m1(logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tm_load   = 1'b0;
        tm_val    = '0;
        hit_clr   = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: if (start) begin
                st_d.ph  = PH_IRST;
                st_d.cfg = cfg_word;
                tm_load  = 1'b1;
                tm_val   = len_m1(cfg_word[IRST_LSB +: CNT_W]);
                hit_clr  = 1'b1;
            end
            PH_IRST: if (tm_exp) begin
                st_d.ph = PH_DRST;
                tm_load = 1'b1;
                tm_val  = len_m1(st_q.cfg[DRST_LSB +: CNT_W]);
            end
            PH_DRST: if (tm_exp) st_d.ph = PH_PRE;
            PH_PRE: begin
                st_d.ph = PH_INJ;
                tm_load = 1'b1;
                tm_val  = len_m1(st_q.cfg[INJ_LSB +: CNT_W]);
            end
            PH_INJ: if (tm_exp) begin
                st_d.ph = PH_SETTLE;
                tm_load = 1'b1;
                tm_val  = (st_q.cfg[SET_LSB +: CNT_W] == '0) ? SETTLE_M1
                        : st_q.cfg[SET_LSB +: CNT_W] - 1'b1;
            end
            PH_SETTLE: if (tm_exp) st_d.ph = PH_POST;
            PH_POST: begin
                st_d.ph = PH_READ;
                tm_load = 1'b1;
                tm_val  = len_m1(st_q.cfg[READ_LSB +: CNT_W]);
            end
            PH_READ: if (tm_exp) begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cfg  <= CFG_RST;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    cds_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_exp)
    );

    cds_hit_latch u_hit (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hit_clr),
        .arm     (phase_armed(st_q.ph)),
        .hit_in  (hit_in),
        .hit_out (hit_out)
    );

    assign int_rst   = (st_q.ph == PH_IRST);
    assign disc_rst  = (st_q.ph == PH_IRST) || (st_q.ph == PH_DRST);
    assign inject    = (st_q.ph == PH_INJ);
    assign samp_pre  = (st_q.ph == PH_PRE);
    assign samp_post = (st_q.ph == PH_POST);
    assign mux_sel   = (st_q.ph == PH_READ);
    assign busy      = (st_q.ph != PH_IDLE);
    assign done      = st_q.done;
    assign cap_sel   = st_q.cfg[2:0];
    assign invert    = st_q.cfg[INV_B];

endmodule

// File: rtl/cds_seq_chk.sv
module cds_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       int_rst,
    input logic       disc_rst,
    input logic       inject,
    input logic       samp_pre,
    input logic       samp_post,
    input logic       mux_sel,
    input logic [2:0] cap_sel,
    input logic       invert,
    input logic       hit_out,
    input logic       busy,
    input logic       done
);

    AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disc_rst, inject, samp_pre, samp_post, mux_sel})); // R7

    AST_IRST_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> disc_rst); // R7

    AST_PRE_ON_DREL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disc_rst) |-> samp_pre); // R3

    AST_POST_TO_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        samp_post |=> mux_sel); // R6

    AST_DONE_AFTER_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mux_sel) && !busy)); // R6

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_rst) |-> !$past(busy)); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cap_sel) && $stable(invert))); // R9

    AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_out && !(start && !busy)) |=> hit_out); // R10

endmodule

bind cds_seq cds_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .int_rst   (int_rst),
    .disc_rst  (disc_rst),
    .inject    (inject),
    .samp_pre  (samp_pre),
    .samp_post (samp_post),
    .mux_sel   (mux_sel),
    .cap_sel   (cap_sel),
    .invert    (invert),
    .hit_out   (hit_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_cds_seq.sv
module tb_cds_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [43:0] cfg_word = '0;
    logic        hit_in = 1'b0;
    logic        int_rst, disc_rst, inject, samp_pre, samp_post, mux_sel;
    logic [2:0]  cap_sel;
    logic        invert, hit_out, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cds_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
        .hit_in(hit_in), .int_rst(int_rst), .disc_rst(disc_rst),
        .inject(inject), .samp_pre(samp_pre), .samp_post(samp_post),
        .mux_sel(mux_sel), .cap_sel(cap_sel), .invert(invert),
        .hit_out(hit_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [43:0] mk(int cap, int inv, int li, int ld,
                                       int lj, int ls, int lr);
        return {8'(lr), 8'(ls), 8'(lj), 8'(ld), 8'(li), 1'(inv), 3'(cap)};
    endfunction

    function automatic int eff(int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic logic [7:0] outs();
        return {int_rst, disc_rst, inject, samp_pre, samp_post, mux_sel, busy, done};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(outs() == 8'h00 && !hit_out, "R1", "outputs in reset", {outs(), hit_out}, 0);
        chk(cap_sel == 3'b111 && !invert, "R1", "cap/inv in reset", {cap_sel, invert}, 4'he);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 8'h00 && !hit_out, "R1", "outputs after reset", {outs(), hit_out}, 0);
        chk(cap_sel == 3'b111 && !invert, "R1", "cap/inv after reset", {cap_sel, invert}, 4'he);
    endtask

    // One full cycle checked against a schedule computed from the counts
    task automatic run_cycle(input int cap, input int inv, input int li, input int ld,
                             input int lj, input int ls, input int lr,
                             input int hit1, input int hit2, input int late_j,
                             input int chg_j, input string hreq);
        int a = eff(li);
        int b = eff(ld);
        int c = eff(lj);
        int s = (ls == 0) ? 15 : ls;
        int r = eff(lr);
        int p_pre = a + b;
        int p_set = p_pre + 1 + c;
        int p_post = p_set + s;
        int total = p_post + 1 + r;
        bit hexp = 1'b0;
        bit hprev = 1'b0;
        int busy_seen = 0;
        logic [7:0] e;
        string req;
        @(negedge clk);
        cfg_word = mk(cap, inv, li, ld, lj, ls, lr);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= total; j++) begin
            e = {j < a, j < p_pre, j > p_pre && j < p_set, j == p_pre,
                 j == p_post, j > p_post && j < total, j < total, j == total};
            if (j < a)            req = "R2";
            else if (j <= p_pre)  req = "R3";
            else if (j < p_set)   req = "R4";
            else if (j <= p_post) req = "R5";
            else                  req = "R6";
            chk(outs() == e, req, $sformatf("switch vector cycle %0d", j), outs(), e);
            chk($onehot0({disc_rst, inject, samp_pre, samp_post, mux_sel}) &&
                (!int_rst || disc_rst), "R7", "exclusive switches", outs(), e);
            chk(hit_out == hexp, hreq, $sformatf("hit_out cycle %0d", j), hit_out, hexp);
            if (j < total)
                chk(cap_sel == 3'(cap) && invert == 1'(inv), "R9", "latched cap/inv",
                    {cap_sel, invert}, {3'(cap), 1'(inv)});
            busy_seen += int'(busy);
            hit_in = (j == hit1) || (j == hit2);
            if (hit_in && !hprev && j >= p_pre && j < total) hexp = 1'b1;
            hprev = hit_in;
            start = (j == late_j);
            if (j == chg_j) cfg_word = ~cfg_word;
            @(posedge clk);
            @(negedge clk);
        end
        hit_in = 1'b0;
        start = 1'b0;
        chk(!busy && !done, "R6", "idle after done", {busy, done}, 0);
        chk(hit_out == hexp, hreq, "hit_out held in idle", hit_out, hexp);
        chk(cap_sel == 3'(cap) && invert == 1'(inv), "R9", "cap/inv held in idle",
            {cap_sel, invert}, {3'(cap), 1'(inv)});
        chk(busy_seen == total, "R8", "busy cycle count", busy_seen, total);
    endtask

    initial begin
        t_reset();
        // basic schedule, hit during settle
        run_cycle(5, 1, 2, 3, 2, 4, 3, 9, -1, -1, -1, "R10");
        // zero counts: minimum lengths and default settle; hit only outside window
        run_cycle(2, 0, 0, 0, 0, 0, 0, 0, 1, -1, -1, "R11");
        // late start and config change mid-cycle, hits at pre-sample and readout
        run_cycle(3, 0, 3, 2, 1, 2, 2, 5, 11, 4, 3, "R10");
        // long intervals, hit pulse in the done cycle is outside the window
        run_cycle(0, 0, 10, 1, 5, 20, 1, 39, -1, -1, -1, "R11");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule